// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This unit keeps the event status of a bus controller and turns it into one interrupt line and two DMA request lines. Logic elsewhere in the controller raises status bits with one-cycle set strobes, one strobe per bit. The host reads and clears the status over a small synchronous register port. A bus-busy indication from outside is merged into status reads but never stored.

The host clears events in two ways. It can write ones to the status register, which clears only the bits that software may acknowledge. It can also read the vector register, which returns the 1-based index of the lowest pending enabled event and clears that event in the same cycle. Enabling DMA for a direction masks that direction's ready interrupt, so ready events go to the DMA engine instead of the CPU.

Register offsets on `reg_addr`: 0 status, 1 interrupt enable, 2 vector, 3 DMA control. Offsets 4 to 7 are unmapped. Read data appears on `reg_rdata` in the cycle after the read strobe and holds until the next read.

Top module: `irqv_unit`

## Requirements
- R1: Reset clears status, interrupt enable and both DMA enables: `irq`, `rx_dreq` and `tx_dreq` are low, and reads of status, enable and DMA control return 0.
- R2: A set strobe on bit i sets status bit i. A status read returns the stored status with `bus_busy` placed at bit 12.
- R3: `irq` is high exactly when the status bits 5..0 ANDed with the enable register are nonzero.
- R4: The enable register keeps only write-data bits 5..0; reads return the upper bits as 0.
- R5: A status write clears each status bit that is set both in the write data and in 0x27 (bits 0, 1, 2, 5). Receive-ready (bit 3) and transmit-ready (bit 4) are never cleared by a write.
- R6: A vector read returns the 1-based position of the lowest set bit of (status AND enable), or 0 if there is none, and clears that status bit at the same edge.
- R7: Writes to the vector register change no state.
- R8: The DMA control register keeps only bit 15 (receive DMA enable) and bit 7 (transmit DMA enable).
- R9: Writing the DMA control register with bit 15 set clears enable bit 3. Writing it with bit 7 set clears enable bit 4.
- R10: `rx_dreq` equals status bit 3 while the receive DMA enable is set and is 0 otherwise. `tx_dreq` equals status bit 4 while the transmit DMA enable is set and is 0 otherwise.
- R11: When a set strobe and a host clear (status write or vector read) act on the same bit in one cycle, the bit ends up set.
- R12: Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_stb | input | 16 | Per-bit status set strobes |
| bus_busy | input | 1 | External bus-busy flag, shown at status bit 12 |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Write data |
| reg_we | input | 1 | Write enable |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | 16 | Registered read data |
| irq | output | 1 | Interrupt request |
| rx_dreq | output | 1 | Receive DMA request |
| tx_dreq | output | 1 | Transmit DMA request |

## Verification
The hardest case to reach from the ports is a collision in a single cycle: a set strobe lands on the very bit that a vector read or a status write is clearing. A random port stimulus hits this only by chance. The bench therefore drives it on purpose, pairing a strobe with a write-one-to-clear and then with a vector read aimed at the same pending bit. A long random phase also mixes strobes, reads and writes so that collisions recur, and a behavioural model is compared against the design on every clock.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int OFS_STAT = 0;
  localparam int OFS_MASK = 1;
  localparam int OFS_VEC  = 2;
  localparam int OFS_DMA  = 3;

  localparam int RX_RDY_BIT = 3;
  localparam int TX_RDY_BIT = 4;
  localparam int BUSY_BIT   = 12;
  localparam int RX_DMA_BIT = 15;
  localparam int TX_DMA_BIT = 7;

  localparam logic [15:0] W1C_BITS = 16'h0027;
endpackage

// File: rtl/irqv_lowest_enc.sv
module irqv_lowest_enc #(
  parameter int N  = 6,
  parameter int IW = $clog2(N + 1)
) (
  input  logic [N-1:0]  pend,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot
);
  always_comb begin
    idx    = '0;
    onehot = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        idx       = IW'(i + 1);
        onehot    = '0;
        onehot[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irqv_status.sv
module irqv_status #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] set_stb,
  input  logic [DW-1:0] clr_w1c,
  input  logic [DW-1:0] clr_vec,
  output logic [DW-1:0] stat_q
);
  logic [DW-1:0] stat_d;
  logic          stat_en;

  always_comb begin
    stat_en = (|set_stb) | (|clr_w1c) | (|clr_vec);
    stat_d  = (stat_q & ~(clr_w1c | clr_vec)) | set_stb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_stb) |=> ((stat_q & $past(set_stb)) == $past(set_stb))); // R11

  AST_RDY_NOT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    ((|clr_w1c) && !(|clr_vec)) |=>
      (($past(stat_q[irqv_pkg::TX_RDY_BIT:irqv_pkg::RX_RDY_BIT]) &
        ~stat_q[irqv_pkg::TX_RDY_BIT:irqv_pkg::RX_RDY_BIT]) == 2'b00)); // R5
endmodule

// File: rtl/irqv_ctrl_regs.sv
module irqv_ctrl_regs #(
  parameter int IEW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_mask,
  input  logic [IEW-1:0] mask_wdata,
  input  logic           wr_dma,
  input  logic           rx_dma_wbit,
  input  logic           tx_dma_wbit,
  output logic [IEW-1:0] mask_q,
  output logic           rx_dma_en,
  output logic           tx_dma_en
);
  logic [IEW-1:0] mask_d;
  logic           mask_en;

  always_comb begin
    mask_en = wr_mask | wr_dma;
    mask_d  = mask_q;
    if (wr_mask) mask_d = mask_wdata;
    if (wr_dma) begin
      if (rx_dma_wbit) mask_d[irqv_pkg::RX_RDY_BIT] = 1'b0;
      if (tx_dma_wbit) mask_d[irqv_pkg::TX_RDY_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_dma_en <= 1'b0;
      tx_dma_en <= 1'b0;
    end else if (wr_dma) begin
      rx_dma_en <= rx_dma_wbit;
      tx_dma_en <= tx_dma_wbit;
    end
  end

  AST_DMA_MASKS_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dma && rx_dma_wbit) |=> !mask_q[irqv_pkg::RX_RDY_BIT]); // R9

  AST_DMA_MASKS_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dma && tx_dma_wbit) |=> !mask_q[irqv_pkg::TX_RDY_BIT]); // R9
endmodule

// File: rtl/irqv_unit.sv
module irqv_unit #(
  parameter int DW  = 16,
  parameter int AW  = 3,
  parameter int IEW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] set_stb,
  input  logic          bus_busy,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          reg_we,
  input  logic          reg_re,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  output logic          rx_dreq,
  output logic          tx_dreq
);
  import irqv_pkg::*;

  localparam int IW = $clog2(IEW + 1);
  localparam logic [AW-1:0] A_STAT = AW'(OFS_STAT);
  localparam logic [AW-1:0] A_MASK = AW'(OFS_MASK);
  localparam logic [AW-1:0] A_VEC  = AW'(OFS_VEC);
  localparam logic [AW-1:0] A_DMA  = AW'(OFS_DMA);

  logic [DW-1:0]  stat_q;
  logic [IEW-1:0] mask_q;
  logic           rx_dma_en, tx_dma_en;
  logic [IEW-1:0] pend, vec_onehot;
  logic [IW-1:0]  vec_idx;
  logic           wr_stat, wr_mask, wr_dma, rd_vec;
  logic [DW-1:0]  clr_w1c, clr_vec;
  logic [DW-1:0]  rd_d;
  logic [DW-1:0]  rdata_q;

  always_comb begin
    wr_stat = reg_we && (reg_addr == A_STAT);
    wr_mask = reg_we && (reg_addr == A_MASK);
    wr_dma  = reg_we && (reg_addr == A_DMA);
    rd_vec  = reg_re && (reg_addr == A_VEC);
    clr_w1c = wr_stat ? (reg_wdata & W1C_BITS) : '0;
    clr_vec = rd_vec ? {{(DW-IEW){1'b0}}, vec_onehot} : '0;
    pend    = stat_q[IEW-1:0] & mask_q;
  end

  irqv_status #(.DW(DW)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_stb (set_stb),
    .clr_w1c (clr_w1c),
    .clr_vec (clr_vec),
    .stat_q  (stat_q)
  );

  irqv_ctrl_regs #(.IEW(IEW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_mask     (wr_mask),
    .mask_wdata  (reg_wdata[IEW-1:0]),
    .wr_dma      (wr_dma),
    .rx_dma_wbit (reg_wdata[RX_DMA_BIT]),
    .tx_dma_wbit (reg_wdata[TX_DMA_BIT]),
    .mask_q      (mask_q),
    .rx_dma_en   (rx_dma_en),
    .tx_dma_en   (tx_dma_en)
  );

  irqv_lowest_enc #(.N(IEW), .IW(IW)) u_enc (
    .pend   (pend),
    .idx    (vec_idx),
    .onehot (vec_onehot)
  );

  always_comb begin
    rd_d = '0;
    unique case (reg_addr)
      A_STAT: begin
        rd_d           = stat_q;
        rd_d[BUSY_BIT] = stat_q[BUSY_BIT] | bus_busy;
      end
      A_MASK: rd_d = {{(DW-IEW){1'b0}}, mask_q};
      A_VEC:  rd_d = {{(DW-IW){1'b0}}, vec_idx};
      A_DMA: begin
        rd_d[RX_DMA_BIT] = rx_dma_en;
        rd_d[TX_DMA_BIT] = tx_dma_en;
      end
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (reg_re) rdata_q <= rd_d;
  end

  assign reg_rdata = rdata_q;
  assign irq       = |pend;
  assign rx_dreq   = stat_q[RX_RDY_BIT] & rx_dma_en;
  assign tx_dreq   = stat_q[TX_RDY_BIT] & tx_dma_en;

  AST_VEC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vec && (|pend) && !(|(set_stb[IEW-1:0] & vec_onehot))) |=>
      !(|(stat_q[IEW-1:0] & $past(vec_onehot)))); // R6

  AST_IRQ_ON_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(set_stb[IEW-1:0] & mask_q)) && !reg_we) |=> irq); // R3
endmodule

// File: tb/irqv_unit_test.sv
`timescale 1ns/1ps
module irqv_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] set_stb = '0;
  logic        bus_busy = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic        reg_re = 1'b0;
  logic [15:0] reg_rdata;
  logic        irq, rx_dreq, tx_dreq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irqv_unit uut (
    .clk(clk), .rst_n(rst_n), .set_stb(set_stb), .bus_busy(bus_busy),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_re(reg_re), .reg_rdata(reg_rdata), .irq(irq),
    .rx_dreq(rx_dreq), .tx_dreq(tx_dreq)
  );

  // behavioural reference
  int    m_stat, m_mask, m_dma, m_rd;
  string m_tag = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat = 0; m_mask = 0; m_dma = 0; m_rd = 0; m_tag = "R1";
    end else begin
      int pend, vec, ns, nm;
      pend = m_stat & m_mask & 'h3f;
      vec = 0;
      for (int i = 5; i >= 0; i--) if (pend[i]) vec = i + 1;
      ns = m_stat; nm = m_mask;
      if (reg_re) begin
        case (reg_addr)
          0: begin m_rd = m_stat | (bus_busy << 12); m_tag = "R2"; end
          1: begin m_rd = m_mask; m_tag = "R4"; end
          2: begin m_rd = vec; m_tag = "R6";
                   if (vec != 0) ns = ns & ~(1 << (vec - 1)); end
          3: begin m_rd = m_dma; m_tag = "R8"; end
          default: begin m_rd = 0; m_tag = "R12"; end
        endcase
      end
      if (reg_we) begin
        case (reg_addr)
          0: ns = ns & ~(reg_wdata & 'h27);
          1: nm = reg_wdata & 'h3f;
          3: begin
               m_dma = reg_wdata & 'h8080;
               if (reg_wdata[15]) nm = nm & ~'h08;
               if (reg_wdata[7])  nm = nm & ~'h10;
             end
          default: ;
        endcase
      end
      m_stat = ns | set_stb;
      m_mask = nm;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int e_irq, e_rx, e_tx;
      e_irq = ((m_stat & m_mask & 'h3f) != 0);
      e_rx  = m_stat[3] & m_dma[15];
      e_tx  = m_stat[4] & m_dma[7];
      chk(irq == e_irq, "R3 irq", irq, e_irq);
      chk(rx_dreq == e_rx, "R10 rx_dreq", rx_dreq, e_rx);
      chk(tx_dreq == e_tx, "R10 tx_dreq", tx_dreq, e_tx);
      chk(reg_rdata == m_rd[15:0], m_tag, reg_rdata, m_rd);
    end
  end

  task automatic idle();
    reg_we = 0; reg_re = 0; set_stb = '0;
  endtask

  task automatic wr(input int a, input int d);
    reg_addr = a[2:0]; reg_wdata = d[15:0]; reg_we = 1;
    @(negedge clk); idle();
  endtask

  task automatic pulse(input int bits);
    set_stb = bits[15:0];
    @(negedge clk); idle();
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    reg_addr = a[2:0]; reg_re = 1;
    @(negedge clk); idle();
    chk(reg_rdata == exp[15:0], tag, reg_rdata, exp);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hang expected=finish");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(irq == 0 && rx_dreq == 0 && tx_dreq == 0, "R1 outputs", {irq, rx_dreq, tx_dreq}, 0);
    rd(0, 0, "R1 status");
    rd(1, 0, "R1 mask");
    rd(3, 0, "R1 dma");
    // R2: set strobes and busy merge
    bus_busy = 1;
    pulse('h0021);
    rd(0, 'h1021, "R2 status+busy");
    chk(irq == 0, "R3 masked", irq, 0);
    // R4: only low 6 enable bits kept
    wr(1, 'hffff);
    rd(1, 'h003f, "R4 mask width");
    chk(irq == 1, "R3 enabled", irq, 1);
    // R5: write-one-to-clear spares ready bits
    bus_busy = 0;
    pulse('h0018);
    wr(0, 'hffff);
    rd(0, 'h0018, "R5 w1c");
    // R6: vector order and clear
    rd(2, 4, "R6 vec first");
    rd(0, 'h0010, "R6 cleared");
    rd(2, 5, "R6 vec second");
    rd(2, 0, "R6 vec empty");
    rd(0, 0, "R6 status empty");
    // R7: vector writes ignored
    pulse('h0002);
    wr(2, 'hffff);
    rd(0, 'h0002, "R7 status kept");
    rd(1, 'h003f, "R7 mask kept");
    // R11: set beats write-clear and vector clear
    set_stb = 16'h0002; reg_addr = 0; reg_wdata = 16'h0002; reg_we = 1;
    @(negedge clk); idle();
    rd(0, 'h0002, "R11 set vs w1c");
    set_stb = 16'h0002; reg_addr = 2; reg_re = 1;
    @(negedge clk); idle();
    chk(reg_rdata == 2, "R11 vec value", reg_rdata, 2);
    rd(0, 'h0002, "R11 set vs vec");
    // R8/R9: dma register and auto masking
    wr(3, 'hffff);
    rd(3, 'h8080, "R8 dma bits");
    rd(1, 'h0027, "R9 mask cleared");
    // R10: dma requests
    pulse('h0008);
    chk(rx_dreq == 1 && tx_dreq == 0, "R10 rx only", {rx_dreq, tx_dreq}, 2);
    pulse('h0010);
    chk(tx_dreq == 1, "R10 tx", tx_dreq, 1);
    wr(3, 0);
    chk(rx_dreq == 0 && tx_dreq == 0, "R10 gated", {rx_dreq, tx_dreq}, 0);
    // R12: unmapped reads
    rd(5, 0, "R12 unmapped");
    // random phase
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom;
      set_stb   = (r[3:0] == 0) ? 16'($urandom) : ((r[5:4] == 0) ? 16'(1 << r[9:6]) : 16'h0);
      bus_busy  = r[10];
      reg_addr  = r[13:11];
      reg_we    = (r[16:14] == 0);
      reg_re    = r[17] & r[18];
      reg_wdata = 16'($urandom);
      @(negedge clk);
    end
    idle();
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule